// File: doc/BRIEF.md
# Three-Word Translation Buffer with Split Permissions

This block holds a 64-entry table of address translations that software loads and inspects one entry at a time, in three 32-bit words. A word-select input chooses which word a write or read touches. Word 0 carries the effective page, a 4-bit size code, an address-space bit and the valid bit. Word 1 carries the real page. Word 2 carries an attribute byte and two permission sets, one for user mode and one for supervisor mode, each with read, write and execute.

A 32-bit control register sits beside the table. Its low byte is the current process ID. A word-0 write tags the entry with that ID, and a word-0 read copies the entry's ID back into that byte. A search port takes an effective address and an address-space bit. It returns a hit flag and the lowest matching index. A single flush pulse tells the surrounding logic that a cached copy of a translation may now be stale.

Top module: `tlb3w_top`

## Requirements
- R1: After reset every entry is invalid, and `rdData`, `ctlReg`, `flushPulse` and `srchHit` are 0. A word-0 read of any entry returns 0.
- R2: A word-0 write sets the entry as follows: page = value[31:10], size code = value[7:4], address-space bit = value[8], valid = value[9]. The entry's process ID is taken from `ctlReg[7:0]`. A word-0 read returns {page, 10'b0} | valid<<9 | space<<8 | code<<4 on `rdData` one cycle after `rdEn`. `rdData` holds its value in cycles with no read.
- R3: A word-0 read puts the entry's process ID into `ctlReg[7:0]` in the same cycle `rdData` updates, and bits 31:8 are kept. If `ctlWrEn` is high in the same cycle, the written value wins. `ctlReg` changes only on these two events.
- R4: A word-1 write stores value & 0xFFFFFC0F as the real page, where the low 4 bits are extra address bits. A word-1 read returns that value.
- R5: A word-2 write stores the attributes from value[15:8], user read/write/execute from bits 0/1/2, and supervisor read/write/execute from bits 3/4/5. All earlier permissions are replaced and the valid bit is not changed. A word-2 read returns attr<<8 | perms, with every other bit 0.
- R6: `entryIdx` is 8 bits wide and only its low 6 bits select the entry.
- R7: A word-select value of 3 acts exactly like word 0, for writes and for reads. Select 1 is the real page and select 2 is attributes and permissions.
- R8: `flushPulse` is high for one cycle, one cycle after a write, in two cases. First, a word-0 write to an entry that was valid before the write, where the new page differs, the new size code is larger, or the new valid bit is 0. Second, a word-1 write to a valid entry whose real page differs. It is 0 in every other cycle, including after any word-2 write.
- R9: `srchHit` and `srchIdx` are valid one cycle after `srchEn`. An entry matches when all of these hold: it is valid, its address-space bit equals `srchSpace`, its process ID is 0 or equals `ctlReg[7:0]`, and the address matches its page under the size mask. The lowest matching index wins. With no match, or in a cycle without a search, both outputs are 0.
- R10: The size mask keeps address bits above 10 + 2·code. A code of 11 or more gives a page that covers the whole 32-bit address, so only the ID and space bit decide the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write the selected word of the selected entry |
| rdEn | input | 1 | Read the selected word of the selected entry |
| wordSel | input | 2 | Word select: 0 or 3 page word, 1 real page, 2 attributes and permissions |
| entryIdx | input | 8 | Entry index; low 6 bits are used |
| wrData | input | 32 | Write value |
| rdData | output | 32 | Read value, registered |
| ctlWrEn | input | 1 | Load the control register |
| ctlWrData | input | 32 | Control register load value |
| ctlReg | output | 32 | Control register; low byte is the process ID |
| srchEn | input | 1 | Start a search |
| srchAddr | input | 32 | Effective address to look up |
| srchSpace | input | 1 | Address-space bit to match |
| srchHit | output | 1 | Search found an entry |
| srchIdx | output | 6 | Lowest matching index |
| flushPulse | output | 1 | Stale-translation flush request |

## Verification
Every result in this block is due exactly one clock after the stimulus that causes it. This covers read data, the process-ID copy into the control register, the flush pulse and the search result. The bench drives each operation one time unit after a rising edge and holds it for a single cycle. It then samples the outputs one time unit after the next rising edge. Each comparison therefore sees the result of exactly that one operation. The expected values come from a reference table in the bench, which is updated in the same order as the design.

// File: rtl/tlb3w_pkg.sv
package tlb3w_pkg;

  localparam int DATA_W  = 32;
  localparam int PAGE_W  = 22;   // effective page bits 31:10
  localparam int SIZE_W  = 4;
  localparam int PID_W   = 8;
  localparam int EXT_W   = 4;    // extra real-address bits
  localparam int ATTR_W  = 8;
  localparam int PERM_W  = 6;
  localparam int MIN_SH  = DATA_W - PAGE_W;   // 10

  typedef struct packed {
    logic [PAGE_W-1:0]       page;
    logic [SIZE_W-1:0]       sizeCode;
    logic                    space;
    logic                    valid;
    logic [PID_W-1:0]        pid;
    logic [PAGE_W+EXT_W-1:0] rpn;
    logic [ATTR_W-1:0]       attr;
    logic [PERM_W-1:0]       perm;
  } entry_t;

  typedef struct packed {
    logic wr0;
    logic wr1;
    logic wr2;
    logic rd0;
    logic rd1;
    logic rd2;
  } strobe_t;

  // Mask of the address bits that take part in the page compare.
  function automatic logic [DATA_W-1:0] sizeMask(input logic [SIZE_W-1:0] code);
    int sh;
    sh = MIN_SH + 2 * int'(code);
    if (sh >= DATA_W) return '0;
    return ~((DATA_W'(1) << sh) - DATA_W'(1));
  endfunction

endpackage

// File: rtl/tlb3w_ctrl.sv
module tlb3w_ctrl
  import tlb3w_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic                    rdEn,
  input  logic [1:0]              wordSel,
  input  logic [PAGE_W:0]         wrHi,      // wrData[31:9]
  input  logic [7:0]              wrLo,      // wrData[7:0]
  input  logic                    ctlWrEn,
  input  logic [DATA_W-1:0]       ctlWrData,
  input  logic                    oldValid,
  input  logic [PAGE_W-1:0]       oldPage,
  input  logic [SIZE_W-1:0]       oldSize,
  input  logic [PAGE_W+EXT_W-1:0] oldRpn,
  input  logic [PID_W-1:0]        oldPid,
  output strobe_t                 stb,
  output logic [DATA_W-1:0]       ctlReg,
  output logic                    flushPulse
);

  logic isW1, isW2, isW0;
  logic needFlush;

  assign isW1 = (wordSel == 2'd1);
  assign isW2 = (wordSel == 2'd2);
  assign isW0 = !isW1 && !isW2;   // selects 0 and 3

  always_comb begin
    stb.wr0 = wrEn && isW0;
    stb.wr1 = wrEn && isW1;
    stb.wr2 = wrEn && isW2;
    stb.rd0 = rdEn && isW0;
    stb.rd1 = rdEn && isW1;
    stb.rd2 = rdEn && isW2;
  end

  always_comb begin
    needFlush = 1'b0;
    if (stb.wr0 && oldValid)
      needFlush = (wrHi[PAGE_W:1] != oldPage) ||
                  (wrLo[7:4] > oldSize) ||
                  !wrHi[0];
    else if (stb.wr1 && oldValid)
      needFlush = ({wrHi[PAGE_W:1], wrLo[EXT_W-1:0]} != oldRpn);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flushPulse <= 1'b0;
      ctlReg     <= '0;
    end else begin
      flushPulse <= needFlush;
      if (ctlWrEn)
        ctlReg <= ctlWrData;
      else if (stb.rd0)
        ctlReg[PID_W-1:0] <= oldPid;
    end
  end

  // R7: at most one word is written per cycle
  p_one_word_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wr0, stb.wr1, stb.wr2}));

  // R8: no flush without a preceding write
  p_flush_needs_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !flushPulse);

  // R8: attribute writes never flush
  p_attr_no_flush_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.wr2 |=> !flushPulse);

  // R3: control register only moves on its own load or a word-0 read
  p_ctl_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlWrEn && !stb.rd0) |=> $stable(ctlReg));

endmodule

// File: rtl/tlb3w_store.sv
module tlb3w_store
  import tlb3w_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = $clog2(ENTRIES)
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [IDX_W-1:0]        idx,
  input  logic [DATA_W-1:0]       wrData,
  input  logic [PID_W-1:0]        curPid,
  input  logic                    srchEn,
  input  logic [DATA_W-1:0]       srchAddr,
  input  logic                    srchSpace,
  output logic                    oldValid,
  output logic [PAGE_W-1:0]       oldPage,
  output logic [SIZE_W-1:0]       oldSize,
  output logic [PAGE_W+EXT_W-1:0] oldRpn,
  output logic [PID_W-1:0]        oldPid,
  output logic [DATA_W-1:0]       rdData,
  output logic                    srchHit,
  output logic [IDX_W-1:0]        srchIdx
);

  entry_t ent [ENTRIES];
  entry_t cur;
  logic [DATA_W-1:0]  rdNext;
  logic [ENTRIES-1:0] hitVec;
  logic               anyHit;
  logic [IDX_W-1:0]   firstIdx;

  assign cur      = ent[idx];
  assign oldValid = cur.valid;
  assign oldPage  = cur.page;
  assign oldSize  = cur.sizeCode;
  assign oldRpn   = cur.rpn;
  assign oldPid   = cur.pid;

  // Table update
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) ent[i] <= '0;
    end else begin
      if (stb.wr0) begin
        ent[idx].page     <= wrData[DATA_W-1:MIN_SH];
        ent[idx].sizeCode <= wrData[7:4];
        ent[idx].space    <= wrData[8];
        ent[idx].valid    <= wrData[9];
        ent[idx].pid      <= curPid;
      end
      if (stb.wr1)
        ent[idx].rpn <= {wrData[DATA_W-1:MIN_SH], wrData[EXT_W-1:0]};
      if (stb.wr2) begin
        ent[idx].attr <= wrData[15:8];
        ent[idx].perm <= wrData[PERM_W-1:0];
      end
    end
  end

  // Read word formatting
  always_comb begin
    rdNext = '0;
    if (stb.rd1)
      rdNext = {cur.rpn[PAGE_W+EXT_W-1:EXT_W], 6'b0, cur.rpn[EXT_W-1:0]};
    else if (stb.rd2)
      rdNext = {16'b0, cur.attr, 2'b0, cur.perm};
    else
      rdNext = {cur.page, cur.valid, cur.space, cur.sizeCode, 4'b0};
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rdData <= '0;
    else if (stb.rd0 || stb.rd1 || stb.rd2)
      rdData <= rdNext;
  end

  // Parallel match, one comparator per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    logic [DATA_W-1:0] diff;
    assign diff = ({ent[g].page, {MIN_SH{1'b0}}} ^ srchAddr) & sizeMask(ent[g].sizeCode);
    assign hitVec[g] = ent[g].valid &&
                       (ent[g].space == srchSpace) &&
                       ((ent[g].pid == '0) || (ent[g].pid == curPid)) &&
                       (diff == '0);
  end

  // Lowest index wins
  always_comb begin
    anyHit   = 1'b0;
    firstIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        anyHit   = 1'b1;
        firstIdx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srchHit <= 1'b0;
      srchIdx <= '0;
    end else if (srchEn) begin
      srchHit <= anyHit;
      srchIdx <= firstIdx;
    end else begin
      srchHit <= 1'b0;
      srchIdx <= '0;
    end
  end

  // R2: read data holds when no read was issued
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.rd0 || stb.rd1 || stb.rd2) |=> $stable(rdData));

  // R9: results only follow a search request
  p_hit_needs_search_r9: assert property (@(posedge clk) disable iff (!rstN)
    !srchEn |=> (!srchHit && srchIdx == '0));

  // R9: a miss reports index 0
  p_miss_idx_r9: assert property (@(posedge clk) disable iff (!rstN)
    !srchHit |-> srchIdx == '0);

endmodule

// File: rtl/tlb3w_top.sv
module tlb3w_top
  import tlb3w_pkg::*;
#(
  parameter int ENTRIES  = 64,
  parameter int IDX_IN_W = 8,
  parameter int IDX_W    = $clog2(ENTRIES)
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [1:0]          wordSel,
  input  logic [IDX_IN_W-1:0] entryIdx,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic                ctlWrEn,
  input  logic [DATA_W-1:0]   ctlWrData,
  output logic [DATA_W-1:0]   ctlReg,
  input  logic                srchEn,
  input  logic [DATA_W-1:0]   srchAddr,
  input  logic                srchSpace,
  output logic                srchHit,
  output logic [IDX_W-1:0]    srchIdx,
  output logic                flushPulse
);

  localparam logic [IDX_IN_W-1:0] IDX_MASK = IDX_IN_W'(ENTRIES - 1);

  strobe_t                 stb;
  logic [IDX_W-1:0]        idx;
  logic [IDX_IN_W-1:0]     idxMasked;
  logic                    oldValid;
  logic [PAGE_W-1:0]       oldPage;
  logic [SIZE_W-1:0]       oldSize;
  logic [PAGE_W+EXT_W-1:0] oldRpn;
  logic [PID_W-1:0]        oldPid;

  assign idxMasked = entryIdx & IDX_MASK;
  assign idx       = idxMasked[IDX_W-1:0];

  tlb3w_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .wordSel    (wordSel),
    .wrHi       (wrData[DATA_W-1:9]),
    .wrLo       (wrData[7:0]),
    .ctlWrEn    (ctlWrEn),
    .ctlWrData  (ctlWrData),
    .oldValid   (oldValid),
    .oldPage    (oldPage),
    .oldSize    (oldSize),
    .oldRpn     (oldRpn),
    .oldPid     (oldPid),
    .stb        (stb),
    .ctlReg     (ctlReg),
    .flushPulse (flushPulse)
  );

  tlb3w_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) uStore (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .idx       (idx),
    .wrData    (wrData),
    .curPid    (ctlReg[PID_W-1:0]),
    .srchEn    (srchEn),
    .srchAddr  (srchAddr),
    .srchSpace (srchSpace),
    .oldValid  (oldValid),
    .oldPage   (oldPage),
    .oldSize   (oldSize),
    .oldRpn    (oldRpn),
    .oldPid    (oldPid),
    .rdData    (rdData),
    .srchHit   (srchHit),
    .srchIdx   (srchIdx)
  );

endmodule

// File: tb/sim_tlb3w_top.sv
`timescale 1ns/1ps
module sim_tlb3w_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0]  wordSel = '0;
  logic [7:0]  entryIdx = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        ctlWrEn = 1'b0;
  logic [31:0] ctlWrData = '0;
  logic [31:0] ctlReg;
  logic        srchEn = 1'b0;
  logic [31:0] srchAddr = '0;
  logic        srchSpace = 1'b0;
  logic        srchHit;
  logic [5:0]  srchIdx;
  logic        flushPulse;

  int nChk = 0;
  int nErr = 0;

  // reference table
  logic [31:0] mPage [64];
  logic [3:0]  mSize [64];
  logic        mSp   [64];
  logic        mVal  [64];
  logic [7:0]  mPid  [64];
  logic [31:0] mRpn  [64];
  logic [7:0]  mAttr [64];
  logic [5:0]  mPerm [64];
  logic [31:0] mCtl;

  always #2 clk = ~clk;

  tlb3w_top u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .wordSel(wordSel),
    .entryIdx(entryIdx), .wrData(wrData), .rdData(rdData),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .ctlReg(ctlReg),
    .srchEn(srchEn), .srchAddr(srchAddr), .srchSpace(srchSpace),
    .srchHit(srchHit), .srchIdx(srchIdx), .flushPulse(flushPulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pageMask(input logic [3:0] sc);
    if (sc >= 4'd11) return 32'h0;
    return 32'hFFFF_FFFF << (10 + 2 * int'(sc));
  endfunction

  function automatic logic [31:0] expWord(input int i, input logic [1:0] ws);
    if (ws == 2'd1) return mRpn[i];
    if (ws == 2'd2) return {16'h0, mAttr[i], 2'b00, mPerm[i]};
    return mPage[i] | (32'(mVal[i]) << 9) | (32'(mSp[i]) << 8) | (32'(mSize[i]) << 4);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic doWrite(input logic [7:0] ix, input logic [1:0] ws, input logic [31:0] v, input string req);
    int i;
    logic ef;
    i = int'(ix[5:0]);
    ef = 1'b0;
    if (ws == 2'd1) begin
      ef = mVal[i] && ((v & 32'hFFFF_FC0F) != mRpn[i]);
      mRpn[i] = v & 32'hFFFF_FC0F;
    end else if (ws == 2'd2) begin
      mAttr[i] = v[15:8];
      mPerm[i] = v[5:0];
    end else begin
      ef = mVal[i] && (((v & 32'hFFFF_FC00) != mPage[i]) || (v[7:4] > mSize[i]) || !v[9]);
      mPage[i] = v & 32'hFFFF_FC00;
      mSize[i] = v[7:4];
      mSp[i]   = v[8];
      mVal[i]  = v[9];
      mPid[i]  = mCtl[7:0];
    end
    wrEn = 1'b1; entryIdx = ix; wordSel = ws; wrData = v;
    tick();
    wrEn = 1'b0;
    check({req, " R8 flush"}, 32'(flushPulse), 32'(ef));
  endtask

  task automatic doRead(input logic [7:0] ix, input logic [1:0] ws, input string req,
                        input logic withCtl, input logic [31:0] cv);
    int i;
    logic [31:0] ew;
    i = int'(ix[5:0]);
    ew = expWord(i, ws);
    if (withCtl) mCtl = cv;
    else if (ws == 2'd0 || ws == 2'd3) mCtl[7:0] = mPid[i];
    rdEn = 1'b1; entryIdx = ix; wordSel = ws;
    ctlWrEn = withCtl; ctlWrData = cv;
    tick();
    rdEn = 1'b0; ctlWrEn = 1'b0;
    check({req, " data"}, rdData, ew);
    check({req, " R3 ctl"}, ctlReg, mCtl);
    check({req, " R8 no flush"}, 32'(flushPulse), 32'd0);
  endtask

  task automatic setCtl(input logic [31:0] v);
    mCtl = v;
    ctlWrEn = 1'b1; ctlWrData = v;
    tick();
    ctlWrEn = 1'b0;
    check("R3 ctl load", ctlReg, mCtl);
  endtask

  task automatic doSearch(input logic [31:0] a, input logic sp, input string req);
    logic eh;
    logic [5:0] ei;
    eh = 1'b0; ei = '0;
    for (int i = 63; i >= 0; i--) begin
      if (mVal[i] && mSp[i] == sp && (mPid[i] == 8'd0 || mPid[i] == mCtl[7:0]) &&
          ((a & pageMask(mSize[i])) == (mPage[i] & pageMask(mSize[i])))) begin
        eh = 1'b1; ei = 6'(i);
      end
    end
    srchEn = 1'b1; srchAddr = a; srchSpace = sp;
    tick();
    srchEn = 1'b0;
    check({req, " hit"}, 32'(srchHit), 32'(eh));
    check({req, " idx"}, 32'(srchIdx), 32'(ei));
  endtask

  logic [21:0] pool [4];

  initial begin
    #(4 * 200000);
    nErr++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    int seedDummy;
    logic [31:0] v;
    seedDummy = $urandom(32'h0BAD_F00D);
    pool[0] = 22'h00_0040; pool[1] = 22'h00_0041; pool[2] = 22'h10_0000; pool[3] = 22'h3F_FFF0;
    for (int i = 0; i < 64; i++) begin
      mPage[i] = '0; mSize[i] = '0; mSp[i] = 1'b0; mVal[i] = 1'b0; mPid[i] = '0;
      mRpn[i] = '0; mAttr[i] = '0; mPerm[i] = '0;
    end
    mCtl = '0;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    check("R1 rdData", rdData, 32'h0);
    check("R1 ctlReg", ctlReg, 32'h0);
    check("R1 flush", 32'(flushPulse), 32'h0);
    check("R1 srchHit", 32'(srchHit), 32'h0);
    doRead(8'd7, 2'd0, "R1 empty entry", 1'b0, 32'h0);
    doSearch(32'h0, 1'b0, "R1 empty search");

    // R2 / R6 word 0 through an index with high bits set
    setCtl(32'h1234_5603);
    doWrite(8'hC5, 2'd0, 32'h0001_2000 | 32'h200 | 32'h100 | 32'h10, "R2 R6 write");
    doRead(8'd5, 2'd0, "R2 read", 1'b0, 32'h0);
    check("R2 literal", rdData, 32'h0001_2310);
    doRead(8'h45, 2'd0, "R6 alias read", 1'b0, 32'h0);

    // R4 real page
    doWrite(8'd5, 2'd1, 32'hABCD_EFFF, "R4 write");
    doRead(8'd5, 2'd1, "R4 read", 1'b0, 32'h0);
    check("R4 literal", rdData, 32'hABCD_EC0F);
    doWrite(8'd5, 2'd1, 32'hABCD_EC0F, "R4 same rpn");

    // R5 permissions and attributes
    doWrite(8'd5, 2'd2, 32'hFFFF_A5FF, "R5 write all");
    doRead(8'd5, 2'd2, "R5 read", 1'b0, 32'h0);
    check("R5 literal", rdData, 32'h0000_A53F);
    doWrite(8'd5, 2'd2, 32'h0000_3C05, "R5 replace");
    doRead(8'd5, 2'd2, "R5 read2", 1'b0, 32'h0);
    check("R5 literal2", rdData, 32'h0000_3C05);
    doRead(8'd5, 2'd0, "R5 valid kept", 1'b0, 32'h0);

    // R7 select 3 behaves as word 0
    doRead(8'd5, 2'd3, "R7 read sel3", 1'b0, 32'h0);
    doWrite(8'd6, 2'd3, 32'h0004_0200, "R7 write sel3");
    doRead(8'd6, 2'd0, "R7 readback", 1'b0, 32'h0);

    // R8 flush corner cases on entry 5 (valid, size 1)
    doWrite(8'd5, 2'd0, 32'h0001_2310, "R8 identical");
    doWrite(8'd5, 2'd0, 32'h0001_2300, "R8 smaller size");
    doWrite(8'd5, 2'd0, 32'h0001_2330, "R8 larger size");
    doWrite(8'd5, 2'd0, 32'h0001_6330, "R8 new page");
    doWrite(8'd5, 2'd0, 32'h0001_6130, "R8 clear valid");
    doWrite(8'd5, 2'd0, 32'h0009_9330, "R8 write invalid");
    doWrite(8'd5, 2'd1, 32'h1111_1111, "R8 rpn change");

    // R3 process ID copy and load priority
    setCtl(32'hFFFF_FF00);
    doRead(8'd5, 2'd0, "R3 pid copy", 1'b0, 32'h0);
    check("R3 literal", ctlReg, 32'hFFFF_FF03);
    doRead(8'd5, 2'd0, "R3 load wins", 1'b1, 32'h0000_0002);

    // R9 lowest index wins, space bit, process ID
    setCtl(32'h0000_0000);
    doWrite(8'd10, 2'd0, 32'h0080_0200, "R9 setup10");
    doWrite(8'd3,  2'd0, 32'h0080_0200, "R9 setup3");
    doSearch(32'h0080_03FF, 1'b0, "R9 lowest");
    doSearch(32'h0080_03FF, 1'b1, "R9 space miss");
    setCtl(32'h0000_0007);
    doWrite(8'd2, 2'd0, 32'h00C0_0200, "R9 pid7");
    setCtl(32'h0000_0004);
    doSearch(32'h00C0_0000, 1'b0, "R9 pid miss");
    setCtl(32'h0000_0007);
    doSearch(32'h00C0_0000, 1'b0, "R9 pid hit");

    // R10 huge page matches any address
    doWrite(8'd40, 2'd0, 32'h0000_03B0, "R10 setup");
    doSearch(32'hDEAD_BEEF, 1'b1, "R10 huge");
    doWrite(8'd41, 2'd0, 32'h1234_0220, "R10 setup 16K");
    doSearch(32'h1234_3FFF, 1'b0, "R10 inside");
    doSearch(32'h1234_4000, 1'b0, "R10 outside");

    // constrained random mix
    for (int k = 0; k < 2000; k++) begin
      int op;
      logic [7:0] ix;
      op = int'($urandom % 7);
      ix = 8'($urandom);
      v = $urandom;
      case (op)
        0, 1: begin
          v[31:10] = pool[$urandom % 4];
          v[7:4] = ($urandom % 5 == 0) ? 4'(11 + $urandom % 5) : 4'($urandom % 4);
          doWrite(ix, 2'(0 + 3 * ($urandom % 2)), v, "R2 R8 rnd w0");
        end
        2: doWrite(ix, 2'd1, ($urandom % 2) ? v : mRpn[ix[5:0]], "R4 R8 rnd w1");
        3: doWrite(ix, 2'd2, v, "R5 rnd w2");
        4: doRead(ix, 2'($urandom), "R7 rnd read", 1'b0, 32'h0);
        5: setCtl({v[31:8], 8'($urandom % 3)});
        default: begin
          v[31:10] = pool[$urandom % 4] ^ 22'($urandom % 4);
          doSearch(v, 1'($urandom), "R9 R10 rnd search");
        end
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

endmodule